// File: doc/BRIEF.md
# Dual-Mode Registered Bus Transceiver

This block links two equal-width ports, A and B, through two independent one-way lanes: A to B, and B to A. Each lane has its own storage word and its own three controls: a pass enable, a capture strobe and an output enable. A lane works in one of three ways. With the pass enable high, the far port shows the near port's data at once. With the pass enable low and the strobe steady, the far port shows the stored word. With the pass enable low, a rising strobe loads the near port's data into storage.

The block runs on one system clock. Each lane samples its strobe on that clock and treats a low-to-high change between two samples as a capture edge. While the pass enable is high, storage reloads from the near port on every system clock edge. When the pass enable drops, storage therefore keeps the last value it took in. Three-state pads are kept outside the block. Each port gives a data vector and a drive flag instead. The B drive flag follows its enable directly. The A drive flag is the inverse of its enable, so the A port is driven only while that enable is low. A synchronous active-low reset clears both storage words.

Top module: `dual_store_xcvr`

## Requirements
- R1: With a lane's pass enable high, that lane's output data equals its input data in the same cycle, with no clock edge needed.
- R2: When the pass enable goes low, the output keeps the input value sampled at the last system clock edge at which the pass enable was high, and later input changes have no effect.
- R3: With the pass enable low and no rising strobe, the output keeps its stored value at every later edge. This holds whether the strobe is held high or held low.
- R4: With the pass enable low, a strobe sampled low at one system edge and high at the next loads the input present at that second edge. The output shows the new value after that edge and not before it.
- R5: A strobe rising while the pass enable is high has no extra effect: the output still follows the input.
- R6: The B-port drive flag is active high: it is 1 when the A-to-B output enable is 1, and 0 when that enable is 0.
- R7: The A-port drive flag is the inverse of the B-to-A enable: it is 1 when that enable is 0, and 0 when that enable is 1.
- R8: Output enables do not touch storage. A capture made while the port is not driven is shown once the port is driven again.
- R9: A synchronous reset, sampled low at a clock edge, clears both storage words to all zeros.
- R10: The two lanes are independent. Any activity on one lane leaves the other lane's held output unchanged.
- R11: Every bit position has its own channel. A single set bit at any position, whether passed or captured, appears at that position only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of both storage words |
| a_i | input | WIDTH | Data arriving on port A (source of the A-to-B lane) |
| a_o | output | WIDTH | Data the B-to-A lane presents to port A |
| a_oe_o | output | 1 | Drive flag for port A (1 = drive) |
| b_i | input | WIDTH | Data arriving on port B (source of the B-to-A lane) |
| b_o | output | WIDTH | Data the A-to-B lane presents to port B |
| b_oe_o | output | 1 | Drive flag for port B (1 = drive) |
| ab_le_i | input | 1 | A-to-B pass enable (1 = pass through) |
| ab_stb_i | input | 1 | A-to-B capture strobe (rising change loads) |
| ab_oe_i | input | 1 | A-to-B output enable, active high |
| ba_le_i | input | 1 | B-to-A pass enable (1 = pass through) |
| ba_stb_i | input | 1 | B-to-A capture strobe (rising change loads) |
| ba_oe_n_i | input | 1 | B-to-A output enable, active low |

## Verification
The hardest case to reach is the pass enable falling while the strobe is already high. The frozen value must be the last word sampled in pass mode, and the high strobe must not count as a new edge. The stimulus raises the strobe during pass mode, waits one edge, and only then drops the pass enable while the input moves to a new value. A second difficult case is a capture made while the port's drive flag is off. The stimulus produces the strobe edge with output disabled and then re-enables the port to show what was stored.

// File: rtl/dsx_pkg.sv
// Shared types for the dual-mode transceiver.
// Assumes: nothing beyond IEEE 1800-2017.
package dsx_pkg;

    // Operating state of one lane during a given clock cycle
    typedef enum logic [1:0] {
        LANE_PASS    = 2'd0,
        LANE_HOLD    = 2'd1,
        LANE_CAPTURE = 2'd2
    } lane_mode_e;

    // True when the storage word must take in the input this cycle
    function automatic logic mode_loads(input lane_mode_e m);
        return (m != LANE_HOLD);
    endfunction

endpackage

// File: rtl/dsx_edge.sv
// Rising-change detector for one lane's capture strobe.
// Sampled on the system clock. Assumes the strobe is synchronous to clk
// or already synchronised upstream. The history flop is not reset so that
// it always reflects the true previous sample.
module dsx_edge (
    input  logic clk,
    input  logic stb_i,
    output logic rise_o
);
    logic stb_q;

    // Keep the previous strobe sample
    always_ff @(posedge clk) begin
        stb_q <= stb_i;
    end

    // Rising change seen between two consecutive samples
    always_comb begin
        rise_o = stb_i & ~stb_q;
    end
endmodule

// File: rtl/dsx_bit.sv
// One-bit storage channel: loads on request and is bypassed in pass mode.
// Assumes the load and pass controls are shared by all bits of a lane.
module dsx_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    input  logic load_i,
    input  logic pass_i,
    output logic q_o
);
    logic store_q;

    // Storage bit: clear on reset, else take the input when asked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= 1'b0;
        end else if (load_i) begin
            store_q <= d_i;
        end
    end

    // Output select: live input in pass mode, stored bit otherwise
    always_comb begin
        q_o = pass_i ? d_i : store_q;
    end
endmodule

// File: rtl/dsx_lane.sv
// One direction of the transceiver: mode decode, strobe edge detection,
// WIDTH storage channels and output enable polarity.
// Assumes: OE_ACTIVE_LOW picks the polarity of oe_i.
module dsx_lane
    import dsx_pkg::*;
#(
    parameter int WIDTH         = 18,
    parameter bit OE_ACTIVE_LOW = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    input  logic             le_i,
    input  logic             stb_i,
    input  logic             oe_i,
    output logic [WIDTH-1:0] q_o,
    output logic             drive_o
);
    localparam int LAST_BIT = WIDTH - 1;

    logic       stb_rise;
    lane_mode_e mode;
    logic       load;

    dsx_edge u_edge (
        .clk    (clk),
        .stb_i  (stb_i),
        .rise_o (stb_rise)
    );

    // Mode decode: pass enable wins over a strobe edge
    always_comb begin
        if (le_i) begin
            mode = LANE_PASS;
        end else if (stb_rise) begin
            mode = LANE_CAPTURE;
        end else begin
            mode = LANE_HOLD;
        end
        load = mode_loads(mode);
    end

    for (genvar i = 0; i <= LAST_BIT; i++) begin : g_bit
        dsx_bit u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_i    (d_i[i]),
            .load_i (load),
            .pass_i (le_i),
            .q_o    (q_o[i])
        );
    end

    if (OE_ACTIVE_LOW) begin : g_oe_low
        // Drive while the enable is low
        always_comb drive_o = ~oe_i;
    end else begin : g_oe_high
        // Drive while the enable is high
        always_comb drive_o = oe_i;
    end
endmodule

// File: rtl/dual_store_xcvr.sv
// Two-port transceiver with an independent pass/hold/capture lane per
// direction. The A-to-B output enable is active high and the B-to-A
// output enable is active low. Pads are external: each port gives data
// plus a drive flag.
module dual_store_xcvr #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_i,
    output logic [WIDTH-1:0] a_o,
    output logic             a_oe_o,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] b_o,
    output logic             b_oe_o,
    input  logic             ab_le_i,
    input  logic             ab_stb_i,
    input  logic             ab_oe_i,
    input  logic             ba_le_i,
    input  logic             ba_stb_i,
    input  logic             ba_oe_n_i
);
    dsx_lane #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b0)) u_ab (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_i     (a_i),
        .le_i    (ab_le_i),
        .stb_i   (ab_stb_i),
        .oe_i    (ab_oe_i),
        .q_o     (b_o),
        .drive_o (b_oe_o)
    );

    dsx_lane #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b1)) u_ba (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_i     (b_i),
        .le_i    (ba_le_i),
        .stb_i   (ba_stb_i),
        .oe_i    (ba_oe_n_i),
        .q_o     (a_o),
        .drive_o (a_oe_o)
    );
endmodule

// File: rtl/dual_store_xcvr_checker.sv
// Port-level temporal checks for dual_store_xcvr, attached by bind.
// Assumes strobes are sampled on clk, as the design does.
module dual_store_xcvr_checker #(
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] a_o,
    input logic [WIDTH-1:0] b_i,
    input logic [WIDTH-1:0] b_o,
    input logic             ab_le_i,
    input logic             ab_stb_i,
    input logic             ba_le_i,
    input logic             ba_stb_i
);
    AST_AB_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le_i |=> (ab_le_i || b_o == $past(a_i)));                    // R2
    AST_BA_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ba_le_i |=> (ba_le_i || a_o == $past(b_i)));                    // R2
    AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le_i && ab_stb_i && !$past(ab_stb_i))
        |=> (ab_le_i || b_o == $past(a_i)));                            // R4
    AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le_i && ba_stb_i && !$past(ba_stb_i))
        |=> (ba_le_i || a_o == $past(b_i)));                            // R4
    AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le_i && !(ab_stb_i && !$past(ab_stb_i)))
        |=> (ab_le_i || $stable(b_o)));                                 // R3
    AST_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le_i && !(ba_stb_i && !$past(ba_stb_i)))
        |=> (ba_le_i || $stable(a_o)));                                 // R3
endmodule

bind dual_store_xcvr dual_store_xcvr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_i      (a_i),
    .a_o      (a_o),
    .b_i      (b_i),
    .b_o      (b_o),
    .ab_le_i  (ab_le_i),
    .ab_stb_i (ab_stb_i),
    .ba_le_i  (ba_le_i),
    .ba_stb_i (ba_stb_i)
);

// File: tb/dual_store_xcvr_bench.sv
module dual_store_xcvr_bench;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_i = '0, b_i = '0;
    logic [W-1:0] a_o, b_o;
    logic         a_oe_o, b_oe_o;
    logic         ab_le_i = 1'b0, ab_stb_i = 1'b0, ab_oe_i = 1'b1;
    logic         ba_le_i = 1'b0, ba_stb_i = 1'b0, ba_oe_n_i = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dual_store_xcvr #(.WIDTH(W)) u_dual_store_xcvr (
        .clk(clk), .rst_n(rst_n),
        .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe_o),
        .b_i(b_i), .b_o(b_o), .b_oe_o(b_oe_o),
        .ab_le_i(ab_le_i), .ab_stb_i(ab_stb_i), .ab_oe_i(ab_oe_i),
        .ba_le_i(ba_le_i), .ba_stb_i(ba_stb_i), .ba_oe_n_i(ba_oe_n_i)
    );

    function automatic logic [W-1:0] pat(input int k);
        return W'(32'h15A3C ^ (k * 32'h0B2D1));
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    // dir 0 = A-to-B lane (source a_i, output b_o); dir 1 = B-to-A lane
    task automatic drive(input bit dir, input logic [W-1:0] v);
        if (dir) b_i = v; else a_i = v;
    endtask
    task automatic set_le(input bit dir, input logic v);
        if (dir) ba_le_i = v; else ab_le_i = v;
    endtask
    task automatic set_stb(input bit dir, input logic v);
        if (dir) ba_stb_i = v; else ab_stb_i = v;
    endtask
    task automatic set_en(input bit dir, input logic en);
        if (dir) ba_oe_n_i = ~en; else ab_oe_i = en;
    endtask
    function automatic logic [W-1:0] outv(input bit dir);
        return dir ? a_o : b_o;
    endfunction
    function automatic logic [W-1:0] drv(input bit dir);
        return W'(dir ? a_oe_o : b_oe_o);
    endfunction

    task automatic run_lane(input bit d);
        bit o = ~d;
        // Park the other lane holding a known word (R10)
        set_le(o, 1'b1); drive(o, pat(20 + d)); tick;
        set_le(o, 1'b0); drive(o, pat(30 + d)); #1;
        chk("R10 other lane held", outv(o), pat(20 + d));
        // Pass mode (R1)
        set_en(d, 1'b1); set_stb(d, 1'b0); set_le(d, 1'b1); drive(d, pat(1)); #1;
        chk("R1 pass first", outv(d), pat(1));
        drive(d, pat(2)); #1;
        chk("R1 pass second", outv(d), pat(2));
        // Strobe edge during pass (R5)
        set_stb(d, 1'b1); tick;
        chk("R5 edge in pass", outv(d), pat(2));
        drive(d, pat(3)); #1;
        chk("R5 still follows", outv(d), pat(3));
        // Freeze with strobe high (R2)
        tick;
        set_le(d, 1'b0); drive(d, pat(4)); #1;
        chk("R2 freeze value", outv(d), pat(3));
        tick;
        chk("R3 hold strobe high", outv(d), pat(3));
        set_stb(d, 1'b0); tick; tick;
        chk("R3 hold strobe low", outv(d), pat(3));
        // Capture (R4)
        drive(d, pat(5)); set_stb(d, 1'b1); #1;
        chk("R4 not before edge", outv(d), pat(3));
        tick;
        chk("R4 captured", outv(d), pat(5));
        drive(d, pat(6)); tick;
        chk("R3 hold after capture", outv(d), pat(5));
        // Capture while not driving (R8)
        set_en(d, 1'b0); #1;
        chk(d ? "R7 disabled flag" : "R6 disabled flag", drv(d), '0);
        drive(d, pat(7)); set_stb(d, 1'b0); tick; set_stb(d, 1'b1); tick;
        set_en(d, 1'b1); #1;
        chk(d ? "R7 enabled flag" : "R6 enabled flag", drv(d), W'(1));
        chk("R8 capture while off", outv(d), pat(7));
        chk("R10 other lane after", outv(o), pat(20 + d));
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset clears both words
        a_i = pat(40); b_i = pat(41);
        tick; tick; tick;
        rst_n = 1'b1; #1;
        chk("R9 reset B side", b_o, '0);
        chk("R9 reset A side", a_o, '0);

        // R6/R7 raw polarity
        ab_oe_i = 1'b1; #1; chk("R6 high enables", W'(b_oe_o), W'(1));
        ab_oe_i = 1'b0; #1; chk("R6 low disables", W'(b_oe_o), '0);
        ba_oe_n_i = 1'b0; #1; chk("R7 low enables", W'(a_oe_o), W'(1));
        ba_oe_n_i = 1'b1; #1; chk("R7 high disables", W'(a_oe_o), '0);

        run_lane(1'b0);
        run_lane(1'b1);

        // R11: single set bit per position, passed and captured
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < W; i++) begin
                set_le(d[0], 1'b1); drive(d[0], W'(1) << i); #1;
                chk("R11 pass one-hot", outv(d[0]), W'(1) << i);
                set_le(d[0], 1'b0); drive(d[0], ~(W'(1) << i));
                set_stb(d[0], 1'b0); tick;
                set_stb(d[0], 1'b1); tick;
                chk("R11 capture one-cold", outv(d[0]), ~(W'(1) << i));
            end
        end

        // R9: reset after data stored
        rst_n = 1'b0; tick; rst_n = 1'b1; #1;
        chk("R9 reset clears stored B", b_o, '0);
        chk("R9 reset clears stored A", a_o, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule